// File: doc/BRIEF.md
# Receive Alarm Change Interrupt Register

This block collects alarm transitions on the receive side of a DS3-style framer. It watches four level conditions supplied by neighbouring logic: out-of-frame, the received application-identification bit, far-end receive failure and idle. It also watches one single-cycle parity-error event. The level conditions are sampled on a per-frame strobe. When a sampled value differs from the one sampled before it, a sticky status bit is set. This happens on both a rising and a falling change. A parity-error pulse sets its own sticky bit whenever it fires.

A small host port exposes three registers. The status byte clears itself when it is read. An enable register masks which status bits drive the combined interrupt output. A third register shows the most recently sampled condition levels, so that software can tell whether an alarm is now present or absent. A change that arrives in the same cycle as a status read is kept for the next read.

Top module: `rx_alarm_irq_reg`

## Requirements
- R1: After reset, the status, enable and live registers all read 0 and `irq` is low.
- R2: Status bits are sticky. They stay set until a read at address 0, and that read sets all status bits to 0, except for bits set in the same cycle.
- R3: Status bit 0 is set in the cycle after any cycle with `perr_evt` high, whether or not `frame_stb` is high.
- R4: The level inputs are sampled only in cycles with `frame_stb` high. Status bit 1 (`oof_in`), bit 2 (`app_id_in`), bit 3 (`far_fail_in`) and bit 4 (`idle_in`) are set when the new sample differs from the previous sample, in either direction. Every previous sample is 0 after reset.
- R5: A change or a parity error in the same cycle as a status read is not lost. The read returns the old status, and the new bit is set afterwards.
- R6: A read at address 2 returns the last sampled levels, in the same bit positions as their status bits, with bit 0 equal to 0. This read does not clear the status.
- R7: Address 1 is a read/write enable register. Bits 4:0 are writable, and bits 7:5 read as 0.
- R8: `irq` is high in the same cycle exactly when some status bit and its enable bit are both 1.
- R9: Bits 7:5 of every read are 0, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_stb | input | 1 | Per-frame sample strobe for the level inputs |
| idle_in | input | 1 | Idle condition level |
| far_fail_in | input | 1 | Far-end receive failure level |
| app_id_in | input | 1 | Received application-identification bit |
| oof_in | input | 1 | Out-of-frame condition level |
| perr_evt | input | 1 | Single-cycle parity-error event |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register select: 0 status, 1 enable, 2 live, 3 unused |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from `addr` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is a new change landing in exactly the cycle in which software clears the status. The read must then return the old byte, and the fresh bit must survive the clear. The bench reaches this case by first leaving a known status. In one cycle it then raises the read strobe, the frame strobe with altered levels and a parity pulse together. It then reads the status again. Every pair of old and new level patterns is swept so that both directions of each transition occur, and a full sweep of status against enable patterns covers the interrupt mask.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned N_LVL  = 4;
  localparam int unsigned N_STAT = N_LVL + 1;
  localparam int unsigned RST_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_ENABLE = 2'd1,
    REG_LIVE   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/alarm_rst_sync.sv
module alarm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/alarm_chg_det.sv
module alarm_chg_det #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] chg_o,
  output logic [WIDTH-1:0] smp_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic smp_q;
    logic smp_d;

    // the held sample only moves on a strobe
    always_comb smp_d = smp_en ? lvl_i[g] : smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= 1'b0;
      else        smp_q <= smp_d;
    end

    // both directions of a transition count
    assign chg_o[g] = smp_en & (lvl_i[g] ^ smp_q);
    assign smp_o[g] = smp_q;
  end
endmodule

// File: rtl/alarm_sticky.sv
module alarm_sticky #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] stat_o
);
  logic [WIDTH-1:0] stat_q;
  logic [WIDTH-1:0] stat_d;

  // set wins over the clear so a change seen during a read survives
  always_comb stat_d = (stat_q & ~{WIDTH{clr_i}}) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/alarm_host_if.sv
module alarm_host_if
  import alarm_irq_pkg::*;
#(
  parameter int unsigned NS = N_STAT,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NS-1:0] status_i,
  input  logic [NS-2:0] live_i,
  output logic [DW-1:0] rdata,
  output logic          clr_o,
  output logic [NS-1:0] en_o,
  output logic          irq_o
);
  localparam int unsigned PAD_W = DW - NS;

  reg_sel_e      sel;
  logic [NS-1:0] en_q;
  logic [NS-1:0] en_d;

  assign sel = reg_sel_e'(addr);

  always_comb begin
    en_d = en_q;
    if (wr_en && sel == REG_ENABLE) en_d = wdata[NS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    unique case (sel)
      REG_STATUS: rdata = {{PAD_W{1'b0}}, status_i};
      REG_ENABLE: rdata = {{PAD_W{1'b0}}, en_q};
      REG_LIVE:   rdata = {{PAD_W{1'b0}}, live_i, 1'b0};
      default:    rdata = '0;
    endcase
  end

  assign clr_o = rd_en && (sel == REG_STATUS);
  assign en_o  = en_q;
  assign irq_o = |(status_i & en_q);
endmodule

// File: rtl/rx_alarm_irq_reg.sv
module rx_alarm_irq_reg
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              idle_in,
  input  logic              far_fail_in,
  input  logic              app_id_in,
  input  logic              oof_in,
  input  logic              perr_evt,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              rst_sync_n;
  logic [N_LVL-1:0]  lvl;
  logic [N_LVL-1:0]  lvl_chg;
  logic [N_LVL-1:0]  lvl_smp;
  logic [N_STAT-1:0] set_vec;
  logic [N_STAT-1:0] status_q;
  logic [N_STAT-1:0] enable_w;
  logic              clr_stat;

  // order sets the status bit positions 4..1
  assign lvl     = {idle_in, far_fail_in, app_id_in, oof_in};
  assign set_vec = {lvl_chg, perr_evt};

  alarm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alarm_chg_det #(.WIDTH(N_LVL)) u_det (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .smp_en (frame_stb),
    .lvl_i  (lvl),
    .chg_o  (lvl_chg),
    .smp_o  (lvl_smp)
  );

  alarm_sticky #(.WIDTH(N_STAT)) u_stat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (set_vec),
    .clr_i  (clr_stat),
    .stat_o (status_q)
  );

  alarm_host_if #(.NS(N_STAT), .DW(DATA_W), .AW(ADDR_W)) u_host (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .status_i (status_q),
    .live_i   (lvl_smp),
    .rdata    (rdata),
    .clr_o    (clr_stat),
    .en_o     (enable_w),
    .irq_o    (irq)
  );
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
  import alarm_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              frame_stb,
  input logic              perr_evt,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [N_STAT-1:0] status,
  input logic [N_STAT-1:0] en,
  input logic [N_STAT-1:0] setv,
  input logic [N_LVL-1:0]  lvl,
  input logic [N_LVL-1:0]  live
);
  logic stat_rd;
  assign stat_rd = rd_en && (addr == ADDR_W'(0));

  AST_PERR_LATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    perr_evt |=> status[0]); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stat_rd |=> ((status & $past(status)) == $past(status))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_rd |=> (status == $past(setv))); // R5
  AST_QUIET_NO_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!frame_stb && !perr_evt) |=> ((status & ~$past(status)) == '0)); // R4
  AST_LIVE_TRACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_stb |=> (live == $past(lvl))); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en == '0) |-> !irq); // R8

  always_comb begin
    if (rst_sync_n) begin
      AST_UPPER_ZERO: assert (rdata[DATA_W-1:N_STAT] == '0); // R9
    end
  end
endmodule

bind rx_alarm_irq_reg alarm_irq_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .frame_stb  (frame_stb),
  .perr_evt   (perr_evt),
  .rd_en      (rd_en),
  .addr       (addr),
  .rdata      (rdata),
  .irq        (irq),
  .status     (status_q),
  .en         (enable_w),
  .setv       (set_vec),
  .lvl        (lvl),
  .live       (lvl_smp)
);

// File: tb/rx_alarm_irq_reg_tb.sv
module rx_alarm_irq_reg_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic       idle_in = 1'b0, far_fail_in = 1'b0, app_id_in = 1'b0, oof_in = 1'b0;
  logic       perr_evt = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int vectors = 0;
  int miscomp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_alarm_irq_reg u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .idle_in(idle_in), .far_fail_in(far_fail_in), .app_id_in(app_id_in),
    .oof_in(oof_in), .perr_evt(perr_evt), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_lvl(input logic [3:0] lv);
    {idle_in, far_fail_in, app_id_in, oof_in} = lv;
  endtask

  task automatic strobe(input logic [3:0] lv, input logic pe);
    @(negedge clk);
    set_lvl(lv);
    perr_evt  = pe;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    perr_evt  = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr  = a;
    rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscomp++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", 32'(d), 32'd0);
    end
    chk("R1 reset irq", 32'(irq), 32'd0);
    rd(2'd3, d);
    chk("R9 unused address", 32'(d), 32'd0);

    // R4 R6 R2: every pair of old and new level patterns
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        strobe(4'(o), 1'b0);
        rd(2'd0, d);
        strobe(4'(n), 1'b0);
        strobe(4'(n), 1'b0);
        rd(2'd2, d);
        chk("R6 live levels", 32'(d), 32'({4'(n), 1'b0}));
        rd(2'd0, d);
        chk("R4 change bits", 32'(d), 32'({4'(o) ^ 4'(n), 1'b0}));
        rd(2'd0, d);
        chk("R2 cleared after read", 32'(d), 32'd0);
      end
    end

    // R4 level moves without a strobe are ignored (levels now 4'hF sampled)
    @(negedge clk);
    set_lvl(4'h0);
    repeat (5) @(negedge clk);
    rd(2'd0, d);
    chk("R4 no strobe no change", 32'(d), 32'd0);
    rd(2'd2, d);
    chk("R4 live held without strobe", 32'(d), 32'h1E);

    // R3 parity pulse outside a strobe
    @(negedge clk);
    perr_evt = 1'b1;
    @(negedge clk);
    perr_evt = 1'b0;
    rd(2'd0, d);
    chk("R3 parity bit", 32'(d), 32'd1);
    rd(2'd0, d);
    chk("R2 parity bit cleared", 32'(d), 32'd0);

    // R5 change and parity error in the cycle of a status read
    @(negedge clk);
    perr_evt = 1'b1;
    @(negedge clk);
    perr_evt  = 1'b0;
    addr      = 2'd0;
    rd_en     = 1'b1;
    frame_stb = 1'b1;
    perr_evt  = 1'b1;
    set_lvl(4'hF ^ 4'b0101);
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; frame_stb = 1'b0; perr_evt = 1'b0;
    chk("R5 read returns old status", 32'(d), 32'd1);
    rd(2'd0, d);
    chk("R5 new bits kept", 32'(d), 32'h0B);

    // R7 R8 R9: every status pattern against every enable pattern
    for (int s = 0; s < 32; s++) begin
      for (int e = 0; e < 32; e++) begin
        strobe(4'h0, 1'b0);
        rd(2'd0, d);
        strobe(4'(s >> 1), 1'(s));
        wr(2'd1, 8'hE0 | 8'(e));
        chk("R8 irq mask", 32'(irq), 32'(|(5'(s) & 5'(e))));
        if (s == 0) begin
          rd(2'd1, d);
          chk("R7 enable readback", 32'(d), 32'(e));
        end
        rd(2'd0, d);
        chk("R9 status byte", 32'(d), 32'(s));
        chk("R8 irq after clear", 32'(irq), 32'd0);
      end
    end

    finish_run();
  end
endmodule